// File: doc/BRIEF.md
# Externally Clocked Serial Slave Channel

This block is one channel of a synchronous serial port that never generates its own bit clock. An outside master drives the shift clock, and on every clock period the channel sends one bit and takes in one bit, so one 8-bit frame goes each way at the same time. The shift clock and the incoming data are sampled into the system clock domain. Every frame boundary comes from edges counted in that domain.

On the CPU side there are plain strobes. A write strobe loads a transmit byte, a read strobe takes the received byte, and a clear input resets the error flags. Received bytes always pass through two stages. The line fills a shifter, and the finished byte moves into a holding register that the CPU reads. The transmit side follows a mode input. In single mode the written byte is what the next frame sends. In double mode writes queue in a second stage, which moves forward when the front stage empties. Double mode also reports underrun when a frame starts with nothing queued. Overrun is reported in both modes when a finished byte finds the holding register still unread. Each completed frame raises one-cycle transmit and receive interrupt pulses.

Top module: `xclk_serial_slave`

## Requirements
- R1: After reset, sdo is 1, tx_irq, rx_irq, ovr_err, unr_err and rx_full are 0.
- R2: Bits on sdi are taken at rising shift clock edges, least significant bit first. After the eighth rising edge of a frame the byte appears on rx_rdata and rx_full reads 1.
- R3: rx_irq pulses for exactly one system clock each time a completed byte moves into the receive holding register.
- R4: If rx_full is still 1 when a frame completes and no read strobe comes in that cycle, ovr_err is set. rx_rdata keeps the old byte, the new byte is dropped, and rx_irq does not pulse.
- R5: A one-cycle rx_rd strobe clears rx_full.
- R6: With dbuf_mode at 0, a frame sends the byte written most recently, least significant bit first. sdo changes after each falling shift clock edge.
- R7: tx_irq pulses for exactly one system clock at the end of every frame, in both modes.
- R8: With dbuf_mode at 1, written bytes are sent in write order, one per frame, through a two-entry queue. The rear entry moves to the front at the end of a frame, or right away when the channel is idle and the front is empty.
- R9: With dbuf_mode at 1, a frame that starts with the front entry empty sets unr_err and sends 8'hFF.
- R10: ovr_err and unr_err stay set until cleared. err_clr bit 0 clears ovr_err and bit 1 clears unr_err. A new error event in the same cycle wins over a clear.
- R11: sdo is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Shift clock from the master, idle high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| dbuf_mode | input | 1 | 1 selects the two-stage transmit queue |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_wdata | input | DATA_W | Transmit byte |
| rx_rd | input | 1 | Receive byte read strobe |
| rx_rdata | output | DATA_W | Receive holding register |
| rx_full | output | 1 | Holding register has an unread byte |
| err_clr | input | 2 | Write-one clear: bit 0 overrun, bit 1 underrun |
| tx_irq | output | 1 | Frame-sent pulse |
| rx_irq | output | 1 | Byte-received pulse |
| ovr_err | output | 1 | Sticky overrun flag |
| unr_err | output | 1 | Sticky underrun flag |

## Verification
The bench uses the default build: 8-bit frames, a two-flop input synchroniser and the transmit queue included. Because the queue is present, dbuf_mode can switch at run time, and the bench runs single mode and double mode in the same run. Reset separates the two phases. The shift clock half-period is eight system clocks, so the three-cycle edge latency stays well inside each bit. That leaves room to test overrun, underrun and the idle-promotion path against a queue model kept in the bench.

// File: rtl/sss_pkg.sv
package sss_pkg;
   // Error flag bit positions inside err_clr
   localparam int ERR_OVR = 0;
   localparam int ERR_UNR = 1;
   localparam int ERR_W   = 2;

   // Frame-control event bundle passed to both data paths
   typedef struct packed {
      logic start;
      logic shift;
      logic sample;
      logic last;
      logic active;
   } frame_ev_t;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("sss_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sss_frame_ctl.sv
module sss_frame_ctl
   import sss_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sclk_s,
   output frame_ev_t ev
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic             sclk_d;
   logic             in_frame;
   logic [CNT_W-1:0] bit_cnt;
   logic             rise, fall;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   assign ev.start  = fall & ~in_frame;
   assign ev.shift  = fall & in_frame;
   assign ev.sample = rise & in_frame;
   assign ev.last   = rise & in_frame & (bit_cnt == LAST_BIT);
   assign ev.active = in_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b1;
         in_frame <= 1'b0;
         bit_cnt  <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (ev.start) in_frame <= 1'b1;
         if (ev.sample) begin
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               in_frame <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sss_tx.sv
module sss_tx
   import sss_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit DBUF_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbuf_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  frame_ev_t         ev,
   output logic              sdo,
   output logic              unr_evt,
   output logic              tx_irq
);
   logic              dbuf_on;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] front;
   logic              front_v;
   logic [DATA_W-1:0] rear;
   logic              rear_f;
   logic              promote;
   logic [DATA_W-1:0] src;

   assign promote = dbuf_on & rear_f & ~front_v & (~ev.active | ev.last);
   assign src     = (dbuf_on & ~front_v) ? '1 : front;
   assign unr_evt = ev.start & dbuf_on & ~front_v;
   assign sdo     = ev.active ? shreg[0] : 1'b1;

   if (DBUF_EN) begin : g_dbuf
      assign dbuf_on = dbuf_mode;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rear   <= '0;
            rear_f <= 1'b0;
         end else begin
            rear_f <= (rear_f & ~promote) | (wr_en & dbuf_on);
            if (wr_en & dbuf_on) rear <= wr_data;
         end
      end
   end else begin : g_single
      logic unused_mode;
      assign unused_mode = dbuf_mode;
      assign dbuf_on     = 1'b0;
      assign rear        = '0;
      assign rear_f      = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '1;
         front   <= '0;
         front_v <= 1'b0;
         tx_irq  <= 1'b0;
      end else begin
         tx_irq <= ev.last;
         if (ev.start)      shreg <= src;
         else if (ev.shift) shreg <= {1'b1, shreg[DATA_W-1:1]};
         if (promote) begin
            front   <= rear;
            front_v <= 1'b1;
         end else if (wr_en & ~dbuf_on) begin
            front   <= wr_data;
            front_v <= 1'b1;
         end else if (ev.start) begin
            front_v <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sss_rx.sv
module sss_rx
   import sss_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdi_s,
   input  frame_ev_t         ev,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              rx_irq,
   output logic              ovr_evt
);
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] hold;
   logic [DATA_W-1:0] byte_in;
   logic              room, accept;

   assign byte_in = {sdi_s, shreg[DATA_W-1:1]};
   assign room    = ~full | rd_en;
   assign accept  = ev.last & room;
   assign ovr_evt = ev.last & ~room;
   assign rd_data = hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         hold   <= '0;
         full   <= 1'b0;
         rx_irq <= 1'b0;
      end else begin
         rx_irq <= accept;
         if (ev.sample) shreg <= byte_in;
         if (accept) begin
            hold <= byte_in;
            full <= 1'b1;
         end else if (rd_en) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xclk_serial_slave.sv
module xclk_serial_slave
   import sss_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit TX_DBUF_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_in,
   input  logic              sdi,
   output logic              sdo,
   input  logic              dbuf_mode,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_full,
   input  logic [ERR_W-1:0]  err_clr,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              ovr_err,
   output logic              unr_err
);
   if (DATA_W < 2) begin : g_bad_width
      $error("xclk_serial_slave: DATA_W must be at least 2");
   end

   logic [1:0] line_s;
   frame_ev_t  ev;
   logic       ovr_evt, unr_evt;

   sss_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk_in, sdi}), .q(line_s)
   );

   sss_frame_ctl #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sclk_s(line_s[1]), .ev(ev)
   );

   sss_tx #(.DATA_W(DATA_W), .DBUF_EN(TX_DBUF_EN)) u_tx (
      .clk(clk), .rst_n(rst_n), .dbuf_mode(dbuf_mode), .wr_en(tx_wr),
      .wr_data(tx_wdata), .ev(ev), .sdo(sdo), .unr_evt(unr_evt),
      .tx_irq(tx_irq)
   );

   sss_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sdi_s(line_s[0]), .ev(ev), .rd_en(rx_rd),
      .rd_data(rx_rdata), .full(rx_full), .rx_irq(rx_irq), .ovr_evt(ovr_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_err <= 1'b0;
         unr_err <= 1'b0;
      end else begin
         if (ovr_evt)               ovr_err <= 1'b1;
         else if (err_clr[ERR_OVR]) ovr_err <= 1'b0;
         if (unr_evt)               unr_err <= 1'b1;
         else if (err_clr[ERR_UNR]) unr_err <= 1'b0;
      end
   end
endmodule

// File: rtl/sss_chk.sv
module sss_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbuf_mode,
   input logic              rx_rd,
   input logic [DATA_W-1:0] rx_rdata,
   input logic              rx_full,
   input logic [1:0]        err_clr,
   input logic              tx_irq,
   input logic              rx_irq,
   input logic              ovr_err,
   input logic              unr_err
);
   a_r3_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);
   a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);
   a_r7_tx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);
   a_r4_ovr_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> $stable(rx_rdata));
   a_r4_ovr_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> !rx_irq);
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |=> (!rx_full || rx_irq));
   a_r9_unr_only_dbuf: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unr_err) |-> dbuf_mode);
   a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && !err_clr[0]) |=> ovr_err);
   a_r10_unr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (unr_err && !err_clr[1]) |=> unr_err);
endmodule

bind xclk_serial_slave sss_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/xclk_serial_slave_bench.sv
module xclk_serial_slave_bench;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_in = 1'b1, sdi = 1'b1, dbuf_mode = 1'b0;
   logic       tx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic [1:0] err_clr = '0;
   logic       sdo, rx_full, tx_irq, rx_irq, ovr_err, unr_err;
   logic [7:0] rx_rdata;

   int errs = 0, checks = 0;
   int rx_irq_n = 0, tx_irq_n = 0;
   bit done = 0;

   always #4 clk = ~clk;

   xclk_serial_slave u_xclk_serial_slave (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdi(sdi), .sdo(sdo),
      .dbuf_mode(dbuf_mode), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .rx_full(rx_full), .err_clr(err_clr),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .ovr_err(ovr_err), .unr_err(unr_err)
   );

   always @(negedge clk) begin
      if (rx_irq) rx_irq_n++;
      if (tx_irq) tx_irq_n++;
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   function automatic logic [7:0] frame_src(input logic fv, input logic [7:0] f);
      return fv ? f : 8'hFF;
   endfunction

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk) begin tx_wr = 1'b1; tx_wdata = b; end
      @(negedge clk) tx_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd();
      @(negedge clk) rx_rd = 1'b1;
      @(negedge clk) rx_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic clr(input logic [1:0] m);
      @(negedge clk) err_clr = m;
      @(negedge clk) err_clr = 2'b00;
      @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk) begin sclk_in = 1'b0; sdi = mosi[i]; end
         repeat (HALF) @(negedge clk);
         miso[i] = sdo;
         sclk_in = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=0 expected=1");
         report();
      end
   end

   initial begin
      logic [7:0] t, m, got, a, b;
      logic [7:0] f, r;
      logic       fv, rf;
      int         ri, ti, nw;
      void'($urandom(32'd20240611));
      do_reset();
      // R1 reset state
      chk(sdo == 1'b1, "R1 sdo", sdo, 1);
      chk({tx_irq, rx_irq, ovr_err, unr_err, rx_full} == 5'b0, "R1 flags",
          {tx_irq, rx_irq, ovr_err, unr_err, rx_full}, 0);

      // Single mode: random traffic
      for (int k = 0; k < 20; k++) begin
         t = 8'($urandom); m = 8'($urandom);
         if (k == 0) begin t = 8'h01; m = 8'h80; end
         if (k == 1) begin t = 8'h00; m = 8'hFF; end
         wr(t);
         ri = rx_irq_n; ti = tx_irq_n;
         xfer(m, got);
         chk(got == t, "R6 tx data", got, t);
         chk(rx_rdata == m && rx_full, "R2 rx data", rx_rdata, m);
         chk(rx_irq_n == ri + 1, "R3 rx_irq count", rx_irq_n - ri, 1);
         chk(tx_irq_n == ti + 1, "R7 tx_irq count", tx_irq_n - ti, 1);
         chk(sdo == 1'b1, "R11 idle sdo", sdo, 1);
         rd();
         chk(rx_full == 1'b0, "R5 read clears", rx_full, 0);
      end
      // single mode resends last byte with no new write, no underrun (R6, R9)
      xfer(8'h3C, got);
      chk(got == t, "R6 resend", got, t);
      chk(unr_err == 1'b0, "R9 no underrun single", unr_err, 0);
      rd();

      // Overrun: two frames without a read (R4)
      a = 8'hA5; b = 8'h5A;
      xfer(a, got);
      ri = rx_irq_n;
      xfer(b, got);
      chk(ovr_err == 1'b1, "R4 overrun flag", ovr_err, 1);
      chk(rx_rdata == a, "R4 old byte kept", rx_rdata, a);
      chk(rx_irq_n == ri, "R4 no rx_irq", rx_irq_n - ri, 0);
      clr(2'b10);
      chk(ovr_err == 1'b1, "R10 wrong bit keeps ovr", ovr_err, 1);
      clr(2'b01);
      chk(ovr_err == 1'b0, "R10 ovr cleared", ovr_err, 0);
      rd();

      // Double mode with a bench queue model (R8, R9)
      do_reset();
      dbuf_mode = 1'b1;
      @(negedge clk);
      fv = 0; rf = 0; f = '0; r = '0;
      for (int k = 0; k < 30; k++) begin
         nw = int'($urandom % 3);
         if (k == 0) nw = 2;
         if (k == 5 || k == 6) nw = 0;
         for (int w = 0; w < nw; w++) begin
            if (!(fv && rf)) begin
               t = 8'($urandom);
               wr(t);
               if (!fv) begin f = t; fv = 1; end
               else begin r = t; rf = 1; end
            end
         end
         m = 8'($urandom);
         ti = tx_irq_n;
         xfer(m, got);
         chk(got == frame_src(fv, f), "R8 queued order", got, frame_src(fv, f));
         chk(unr_err == !fv, "R9 underrun flag", unr_err, !fv);
         chk(tx_irq_n == ti + 1, "R7 tx_irq dbuf", tx_irq_n - ti, 1);
         chk(rx_rdata == m, "R2 rx dbuf", rx_rdata, m);
         fv = 0;
         if (rf) begin f = r; fv = 1; rf = 0; end
         rd();
         if (unr_err) begin
            clr(2'b10);
            chk(unr_err == 1'b0, "R10 unr cleared", unr_err, 0);
         end
      end
      done = 1;
      report();
   end
endmodule